// File: doc/BRIEF.md
# Grouped Interrupt Aggregation Controller

This block gathers a large number of peripheral interrupt lines and reduces them to a small set of interrupt outputs for a downstream interrupt controller. Sources arrive in groups of 32. Each group has an enable mask and a sticky status word. A source that is high while its enable bit is 1 sets its status bit. The bit stays set until software clears it by writing a 1 to it. Both words of every group are reached through a single-cycle register port with a 32-bit data bus.

Groups come in two kinds. An ordinary group reduces its masked status word to one output with an OR. The split group is group 0 by default. It does not reduce: each of its low ten status bits, masked by the matching enable bit, drives an output of its own. With the defaults there are ten groups and nineteen outputs. Outputs 0 to 9 belong to the split group, and output 9+k belongs to ordinary group k (k = 1..9). A parameter removes the split group, which gives a reduced build in which every group drives exactly one output.

Top module: `irq_group_ctrl`

## Requirements
- R1: After reset every enable and status word is zero, `irq_o` is all zero and `reg_rdata_o` is zero.
- R2: An enable word is plain read/write across all 32 bits. A write takes effect on the next clock edge and changes no other word.
- R3: A status bit becomes 1 on the clock edge where its source line is high and its enable bit (the value before that edge) is 1. If the enable bit is 0, the source has no effect on status.
- R4: A status bit that is set stays 1 after its source returns low, until software clears it.
- R5: Writing a 1 to a status bit clears it and writing a 0 leaves it unchanged. If the source and enable are both still 1 on the edge of the clearing write, the bit stays 1.
- R6: For ordinary group k, `irq_o[9+k]` is 1 exactly when some bit of (status AND enable) of that group is 1. Clearing an enable bit masks the output, but the status bit keeps its value.
- R7: In the split group, `irq_o[n]` for n = 0..9 equals status bit n AND enable bit n. Bits 10..31 of the split group latch as usual but drive no output.
- R8: Register map on the 14-bit byte address: the enable word of group k is at 0x1000 + k*0x80 and its status word is at 0x1004 + k*0x80, for k = 0..9. Any other address, whether below 0x1000, at another offset inside a group slot, beyond the last group, or not word aligned, reads as zero and is not changed by a write.
- R9: `reg_rdata_o` shows the word that was addressed with `reg_rd_i` high, one clock after that strobe. In every cycle that follows a clock without a read strobe it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 320 | Source lines; group k uses bits [32k+31:32k] |
| reg_addr_i | input | 14 | Register byte address |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, one cycle after the read strobe |
| irq_o | output | 19 | Interrupt outputs (0..9 split group, 10..18 ordinary groups) |

## Verification
The bench targets the race between a clearing write and a source that is still active. A design that lets the clear win drops an interrupt that is still pending. It checks that the set condition uses the enable value from before the edge, so an enable write in the same cycle cannot set or block a bit early. It checks that status bits 10..31 of the split group stay off the outputs; a design that ORs them into output 9 or into an ordinary output shows a spurious interrupt. Writes and reads at addresses below the window, at unused offsets and at unaligned addresses are checked as well. A decoder that drops the low address bits would alias these accesses onto live registers and corrupt them.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int unsigned WORD_W = 32;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_EN   = 2'd1,
        SEL_ST   = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic [WORD_W-1:0] en;
        logic [WORD_W-1:0] st;
    } grp_state_t;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import irq_agg_pkg::*;
#(
    parameter int unsigned ADDR_W     = 14,
    parameter int unsigned WIN_BASE   = 32'h1000,
    parameter int unsigned WIN_SPAN   = 32'h808,
    parameter int unsigned STRIDE_LG  = 7,
    parameter int unsigned NUM_GROUPS = 10,
    parameter int unsigned GRP_W      = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_e          sel_o,
    output logic [GRP_W-1:0]  grp_o
);
    localparam logic [STRIDE_LG-1:0] OFF_EN = '0;
    localparam logic [STRIDE_LG-1:0] OFF_ST = STRIDE_LG'(4);

    logic [ADDR_W-1:0]    off;
    logic [ADDR_W-1:0]    grp_raw;
    logic [STRIDE_LG-1:0] sub;
    logic                 in_win;
    logic                 grp_ok;

    always_comb begin
        off     = addr_i - ADDR_W'(WIN_BASE);
        grp_raw = off >> STRIDE_LG;
        sub     = off[STRIDE_LG-1:0];
        in_win  = (32'(addr_i) >= WIN_BASE) && (32'(addr_i) < WIN_BASE + WIN_SPAN);
        grp_ok  = 32'(grp_raw) < NUM_GROUPS;
        grp_o   = grp_raw[GRP_W-1:0];
        sel_o   = SEL_NONE;
        if (in_win && grp_ok) begin
            if (sub == OFF_EN)      sel_o = SEL_EN;
            else if (sub == OFF_ST) sel_o = SEL_ST;
        end
    end
endmodule

// File: rtl/irq_group_bank.sv
module irq_group_bank
    import irq_agg_pkg::*;
#(
    parameter int unsigned GRP_ID = 0,
    parameter int unsigned GRP_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] src_i,
    input  logic              wr_i,
    input  reg_sel_e          sel_i,
    input  logic [GRP_W-1:0]  grp_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] en_o,
    output logic [WORD_W-1:0] st_o
);
    grp_state_t state_d, state_q;
    logic       hit;
    logic [WORD_W-1:0] clr;

    always_comb begin
        hit     = wr_i && (grp_i == GRP_W'(GRP_ID));
        clr     = (hit && sel_i == SEL_ST) ? wdata_i : '0;
        state_d = state_q;
        if (hit && sel_i == SEL_EN) state_d.en = wdata_i;
        // a live, enabled source outranks a clearing write
        state_d.st = (state_q.st & ~clr) | (src_i & state_q.en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign en_o = state_q.en;
    assign st_o = state_q.st;
endmodule

// File: rtl/irq_out_map.sv
module irq_out_map
    import irq_agg_pkg::*;
#(
    parameter int unsigned NUM_GROUPS = 10,
    parameter bit          HAS_SPLIT  = 1'b1,
    parameter int unsigned SPLIT_OUTS = 10,
    parameter int unsigned OUT_W      = 19
) (
    input  logic [NUM_GROUPS*WORD_W-1:0] en_all_i,
    input  logic [NUM_GROUPS*WORD_W-1:0] st_all_i,
    output logic [OUT_W-1:0]             irq_o
);
    logic [NUM_GROUPS*WORD_W-1:0] pend;
    assign pend = en_all_i & st_all_i;

    generate
        if (HAS_SPLIT) begin : g_split
            for (genvar n = 0; n < SPLIT_OUTS; n++) begin : g_bit
                assign irq_o[n] = pend[n];
            end
            for (genvar k = 1; k < NUM_GROUPS; k++) begin : g_or
                assign irq_o[SPLIT_OUTS+k-1] = |pend[k*WORD_W +: WORD_W];
            end
            logic unused_hi;
            assign unused_hi = |pend[WORD_W-1:SPLIT_OUTS];
        end else begin : g_flat
            for (genvar k = 0; k < NUM_GROUPS; k++) begin : g_or
                assign irq_o[k] = |pend[k*WORD_W +: WORD_W];
            end
        end
    endgenerate
endmodule

// File: rtl/irq_group_ctrl.sv
module irq_group_ctrl
    import irq_agg_pkg::*;
#(
    parameter int unsigned NUM_GROUPS = 10,
    parameter bit          HAS_SPLIT  = 1'b1,
    parameter int unsigned SPLIT_OUTS = 10,
    parameter int unsigned ADDR_W     = 14,
    parameter int unsigned WIN_BASE   = 32'h1000,
    parameter int unsigned WIN_SPAN   = 32'h808,
    parameter int unsigned STRIDE_LG  = 7,
    localparam int unsigned SRC_W     = NUM_GROUPS * WORD_W,
    localparam int unsigned OUT_W     = HAS_SPLIT ? (SPLIT_OUTS + NUM_GROUPS - 1) : NUM_GROUPS,
    localparam int unsigned GRP_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_W-1:0]  src_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [WORD_W-1:0] reg_wdata_i,
    output logic [WORD_W-1:0] reg_rdata_o,
    output logic [OUT_W-1:0]  irq_o
);
    reg_sel_e          sel;
    logic [GRP_W-1:0]  grp;
    logic [SRC_W-1:0]  en_all;
    logic [SRC_W-1:0]  st_all;
    logic [WORD_W-1:0] rdata_d, rdata_q;

    irq_reg_decode #(
        .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_SPAN(WIN_SPAN),
        .STRIDE_LG(STRIDE_LG), .NUM_GROUPS(NUM_GROUPS), .GRP_W(GRP_W)
    ) u_dec (
        .addr_i(reg_addr_i), .sel_o(sel), .grp_o(grp)
    );

    generate
        for (genvar k = 0; k < NUM_GROUPS; k++) begin : g_bank
            irq_group_bank #(.GRP_ID(k), .GRP_W(GRP_W)) u_bank (
                .clk(clk), .rst_n(rst_n),
                .src_i(src_i[k*WORD_W +: WORD_W]),
                .wr_i(reg_wr_i), .sel_i(sel), .grp_i(grp),
                .wdata_i(reg_wdata_i),
                .en_o(en_all[k*WORD_W +: WORD_W]),
                .st_o(st_all[k*WORD_W +: WORD_W])
            );
        end
    endgenerate

    irq_out_map #(
        .NUM_GROUPS(NUM_GROUPS), .HAS_SPLIT(HAS_SPLIT),
        .SPLIT_OUTS(SPLIT_OUTS), .OUT_W(OUT_W)
    ) u_map (
        .en_all_i(en_all), .st_all_i(st_all), .irq_o(irq_o)
    );

    always_comb begin
        rdata_d = '0;
        if (reg_rd_i) begin
            for (int k = 0; k < NUM_GROUPS; k++) begin
                if (grp == GRP_W'(k)) begin
                    if (sel == SEL_EN)      rdata_d = en_all[k*WORD_W +: WORD_W];
                    else if (sel == SEL_ST) rdata_d = st_all[k*WORD_W +: WORD_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign reg_rdata_o = rdata_q;
endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker #(
    parameter int unsigned NW       = 320,
    parameter int unsigned OUT_W    = 19,
    parameter int unsigned ADDR_W   = 14,
    parameter int unsigned WIN_BASE = 32'h1000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NW-1:0]     src_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic              reg_wr_i,
    input logic              reg_rd_i,
    input logic [31:0]       reg_rdata_o,
    input logic [OUT_W-1:0]  irq_o,
    input logic [NW-1:0]     en_all,
    input logic [NW-1:0]     st_all
);
    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_i |=> reg_rdata_o == '0); // R9

    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr_i |=> $stable(en_all)); // R2

    AST_NO_SET_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_all & ~$past(st_all)) & ~$past(src_i & en_all)) == '0); // R3

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr_i |=> ((st_all & $past(st_all)) == $past(st_all))); // R4

    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o != '0) |-> ((st_all & en_all) != '0)); // R6

    AST_LOW_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && 32'(reg_addr_i) < WIN_BASE) |=> $stable(en_all)); // R8
endmodule

bind irq_group_ctrl irq_agg_checker #(
    .NW(SRC_W), .OUT_W(OUT_W), .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_addr_i(reg_addr_i),
    .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i), .reg_rdata_o(reg_rdata_o),
    .irq_o(irq_o), .en_all(en_all), .st_all(st_all)
);

// File: tb/tb_irq_group_ctrl.sv
module tb_irq_group_ctrl;
    localparam int NG = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [319:0] src = '0;
    logic [13:0]  addr = '0;
    logic         wr = 1'b0;
    logic         rd = 1'b0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic [18:0]  irq;

    logic [31:0] en_m [NG];
    logic [31:0] st_m [NG];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    irq_group_ctrl dut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .reg_addr_i(addr),
        .reg_wr_i(wr), .reg_rd_i(rd), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq)
    );

    always #10 clk = ~clk;

    function automatic logic [13:0] a_en(input int k);
        return 14'(32'h1000 + k * 32'h80);
    endfunction
    function automatic logic [13:0] a_st(input int k);
        return 14'(32'h1004 + k * 32'h80);
    endfunction

    // 0 none, 1 enable, 2 status; group in g
    function automatic int decode(input logic [13:0] a, output int g);
        int o;
        g = 0;
        if (a < 14'h1000 || a >= 14'h1808) return 0;
        o = int'(a) - 32'h1000;
        g = o / 128;
        if (g >= NG) return 0;
        if (o % 128 == 0) return 1;
        if (o % 128 == 4) return 2;
        return 0;
    endfunction

    function automatic logic [18:0] exp_irq();
        logic [18:0] v = '0;
        for (int n = 0; n < 10; n++) v[n] = st_m[0][n] & en_m[0][n];
        for (int k = 1; k < NG; k++) v[9+k] = |(st_m[k] & en_m[k]);
        return v;
    endfunction

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic tick(input logic [319:0] s, input logic [13:0] a, input logic w,
                        input logic r, input logic [31:0] d);
        int g, kind;
        logic [31:0] rexp;
        logic [31:0] en_old [NG];
        logic [18:0] ie;
        src = s; addr = a; wr = w; rd = r; wdata = d;
        @(posedge clk);
        kind = decode(a, g);
        rexp = 32'h0;
        if (r && kind == 1) rexp = en_m[g];
        if (r && kind == 2) rexp = st_m[g];
        for (int k = 0; k < NG; k++) en_old[k] = en_m[k];
        if (w && kind == 1) en_m[g] = d;
        for (int k = 0; k < NG; k++) begin
            logic [31:0] c;
            c = (w && kind == 2 && g == k) ? d : 32'h0;
            st_m[k] = (st_m[k] & ~c) | (s[k*32 +: 32] & en_old[k]);
        end
        @(negedge clk);
        ie = exp_irq();
        chk(32'(irq[9:0]), 32'(ie[9:0]), "R7 split outputs");
        chk(32'(irq[18:10]), 32'(ie[18:10]), "R6 group outputs");
        if (!r)            chk(rdata, rexp, "R9 idle read data");
        else if (kind == 0) chk(rdata, rexp, "R8 unmapped read");
        else               chk(rdata, rexp, "R2 register read");
        src = s; wr = 1'b0; rd = 1'b0;
    endtask

    task automatic rd_chk(input logic [13:0] a, input logic [31:0] exp, input string tag);
        tick(src, a, 1'b0, 1'b1, 32'h0);
        chk(rdata, exp, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [319:0] s;
        void'($urandom(32'd7310));
        for (int k = 0; k < NG; k++) begin en_m[k] = '0; st_m[k] = '0; end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(32'(irq), 32'h0, "R1 irq after reset");
        chk(rdata, 32'h0, "R1 rdata after reset");
        rst_n = 1'b1;
        @(negedge clk);
        rd_chk(a_en(3), 32'h0, "R1 enable reset");
        rd_chk(a_st(0), 32'h0, "R1 status reset");

        // R2: enable read/write
        tick('0, a_en(2), 1'b1, 1'b0, 32'hA5A5_0F0F);
        rd_chk(a_en(2), 32'hA5A5_0F0F, "R2 enable readback");
        rd_chk(a_en(3), 32'h0, "R2 neighbour untouched");

        // R3/R6: enabled source sets status, output group 2 -> irq[11]
        s = '0; s[2*32 + 0] = 1'b1; s[2*32 + 4] = 1'b1;
        tick(s, 14'h0, 1'b0, 1'b0, 32'h0);
        chk(32'(irq[11]), 32'h1, "R6 group 2 output");
        tick('0, 14'h0, 1'b0, 1'b0, 32'h0);
        rd_chk(a_st(2), 32'h1, "R3 masked bit4 not set, R4 bit0 sticky");

        // R5: write 0 keeps, write 1 clears
        tick('0, a_st(2), 1'b1, 1'b0, 32'h0);
        rd_chk(a_st(2), 32'h1, "R5 zero write keeps");
        tick('0, a_st(2), 1'b1, 1'b0, 32'h1);
        rd_chk(a_st(2), 32'h0, "R5 one write clears");
        chk(32'(irq[11]), 32'h0, "R6 output drops after clear");

        // R5: source still active wins over clear
        s = '0; s[2*32 + 1] = 1'b1;
        tick(s, 14'h0, 1'b0, 1'b0, 32'h0);
        tick(s, a_st(2), 1'b1, 1'b0, 32'h2);
        tick('0, 14'h0, 1'b0, 1'b0, 32'h0);
        rd_chk(a_st(2), 32'h2, "R5 set wins over clear");

        // R6: masking keeps status
        tick('0, a_en(2), 1'b1, 1'b0, 32'h0);
        chk(32'(irq[11]), 32'h0, "R6 masked output");
        rd_chk(a_st(2), 32'h2, "R6 status kept when masked");

        // R7: split group
        tick('0, a_en(0), 1'b1, 1'b0, 32'h0010_03FF);
        s = '0; s[3] = 1'b1; s[20] = 1'b1;
        tick(s, 14'h0, 1'b0, 1'b0, 32'h0);
        tick('0, 14'h0, 1'b0, 1'b0, 32'h0);
        chk(32'(irq[9:0]), 32'h8, "R7 only bit 3 drives");
        chk(32'(irq[18:10]), 32'h0, "R7 bit 20 drives nothing");
        rd_chk(a_st(0), 32'h0010_0008, "R7 high bit latched");

        // R8: unmapped accesses
        tick('0, 14'h0000, 1'b1, 1'b0, 32'hFFFF_FFFF);
        tick('0, 14'h1008, 1'b1, 1'b0, 32'hFFFF_FFFF);
        tick('0, 14'h1001, 1'b1, 1'b0, 32'hFFFF_FFFF);
        rd_chk(a_en(0), 32'h0010_03FF, "R8 enable untouched");
        rd_chk(14'h0000, 32'h0, "R8 low address reads zero");
        rd_chk(14'h1008, 32'h0, "R8 slot gap reads zero");
        rd_chk(14'h1001, 32'h0, "R8 unaligned reads zero");
        rd_chk(14'h1500, 32'h0, "R8 past last group reads zero");
        rd_chk(a_en(9), 32'h0, "R8 last group enable");

        // R9: no read, zero data
        tick('0, a_en(0), 1'b0, 1'b0, 32'h0);
        chk(rdata, 32'h0, "R9 idle data zero");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [319:0] rs;
            logic [13:0]  ra;
            int op, gk;
            for (int k = 0; k < 10; k++) rs[k*32 +: 32] = $urandom & $urandom & $urandom;
            gk = $urandom % NG;
            ra = ($urandom % 2) ? a_st(gk) : a_en(gk);
            op = $urandom % 8;
            case (op)
                0, 1, 2: tick(rs, ra, 1'b1, 1'b0, $urandom);
                3, 4, 5: tick(rs, ra, 1'b0, 1'b1, 32'h0);
                6:       tick(rs, 14'($urandom), $urandom % 2 == 0, 1'b1, $urandom);
                default: tick(rs, ra, 1'b0, 1'b0, 32'h0);
            endcase
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule